// File: doc/BRIEF.md
# One-Hot Population Tally

This block counts how many of its N single-bit inputs are set and presents the result as a one-hot vector of N+1 lines: the single high line sits at the position equal to the number of set inputs. With all inputs clear, line 0 is high; with all inputs set, line N is high.

The count is formed by a chain of identical steering stages, one per input bit. Each stage receives a one-hot vector from the stage before it. When its own input bit is clear, it passes every line through to the same position. When its bit is set, it moves every line up by one position. The first stage is fed a vector with only line 0 set. Every line is always driven, and a line that receives no routed value is driven low.

A parameter chooses the output stage. It is either purely combinational or registered, and the registered form has a synchronous reset that returns the output to line 0.

Top module: `tally_onehot`

## Requirements
- R1: The output has N+1 bits, and exactly one of them is high at all times (after reset when registered).
- R2: The index of the high output bit equals the number of input bits that are 1.
- R3: A stage whose control bit is 0 presents its incoming vector unchanged at the same positions.
- R4: A stage whose control bit is 1 moves each incoming line to the next higher position and drives position 0 low.
- R5: With every input bit 0, output bit 0 is high. With every input bit 1, output bit N is high.
- R6: In the registered mode (MODE = OUT_REG), the output shows the tally of the inputs sampled at the previous rising clock edge and holds it until the next edge.
- R7: In the registered mode, a high `rst` at a rising edge loads the value with only bit 0 set, whatever the inputs are.
- R8: In the combinational mode (MODE = OUT_COMB), the output follows the inputs without any clock edge.
- R9: Only the number of set inputs affects the output. Inputs with the same count in different bit positions give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bits_i | input | N | Bits to be tallied |
| onehot_o | output | N+1 | One-hot tally; the high bit's index is the count of set inputs |

## Verification
In the registered mode, a synchronous reset and a fresh input pattern can arrive at the same clock edge. The bench provokes this by holding every input at 1 and raising `rst` for one edge. The output must show bit 0 high and not bit N, so reset wins. On the following edge, with `rst` low and the inputs unchanged, the output must move to bit N.

// File: rtl/tally_pkg.sv
package tally_pkg;

    // Selects how the tally leaves the block.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/tally_stage.sv
module tally_stage #(
    parameter int W = 5
) (
    input  logic [W-1:0] vec_i,
    input  logic         bit_i,
    output logic [W-1:0] vec_o
);

    // Bottom line: nothing can be routed into it on a shift, so it is forced low.
    assign vec_o[0] = bit_i ? 1'b0 : vec_i[0];

    for (genvar p = 1; p < W; p++) begin : g_pos
        assign vec_o[p] = bit_i ? vec_i[p-1] : vec_i[p];
    end

    // R3/R4: when the top line is free, routing neither creates nor loses lines.
    always_comb begin
        if (!vec_i[W-1]) begin
            p_conserve_r3: assert ($countones(vec_o) == $countones(vec_i))
                else $error("stage changed number of active lines");
        end
    end

endmodule

// File: rtl/tally_cascade.sv
module tally_cascade #(
    parameter int N = 4
) (
    input  logic [N-1:0] bits_i,
    output logic [N:0]   onehot_o
);

    localparam int W = N + 1;
    localparam logic [W-1:0] SEED = W'(1);

    logic [W-1:0] chain [0:N];

    assign chain[0] = SEED;

    for (genvar k = 0; k < N; k++) begin : g_stage
        tally_stage #(.W(W)) u_stage (
            .vec_i (chain[k]),
            .bit_i (bits_i[k]),
            .vec_o (chain[k+1])
        );
    end

    assign onehot_o = chain[N];

    // R1: the end of the chain carries exactly one active line.
    always_comb begin
        p_chain_onehot_r1: assert ($onehot(onehot_o))
            else $error("cascade output not one-hot");
    end

endmodule

// File: rtl/tally_onehot.sv
module tally_onehot
    import tally_pkg::*;
#(
    parameter int        N    = 4,
    parameter out_mode_e MODE = OUT_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] bits_i,
    output logic [N:0]   onehot_o
);

    localparam int W = N + 1;
    localparam logic [W-1:0] IDLE = W'(1);

    logic [W-1:0] tally_w;

    tally_cascade #(.N(N)) u_cascade (
        .bits_i   (bits_i),
        .onehot_o (tally_w)
    );

    if (MODE == OUT_REG) begin : g_reg
        typedef struct packed {
            logic [W-1:0] vec;
        } out_state_t;

        out_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (rst) begin
                st_d.vec = IDLE;
            end else begin
                st_d.vec = tally_w;
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign onehot_o = st_q.vec;

        p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
            $onehot(onehot_o))
            else $error("registered tally not one-hot");

        p_reset_r7: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> onehot_o == IDLE)
            else $error("reset did not leave bit 0 set");

        p_empty_r5: assert property (@(posedge clk) disable iff (rst)
            (bits_i == '0) |=> onehot_o == IDLE)
            else $error("all-zero inputs not tallied as zero");

        p_full_r5: assert property (@(posedge clk) disable iff (rst)
            (&bits_i) |=> onehot_o[N])
            else $error("all-one inputs not tallied as N");
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign onehot_o = tally_w;
    end

endmodule

// File: tb/tally_onehot_bench.sv
module tally_onehot_bench;
    import tally_pkg::*;

    localparam int N = 4;
    localparam int W = N + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] bits = '0;
    logic [N:0] out_reg, out_comb;
    logic [W-1:0] pv_in = '0;
    logic pbit = 1'b0;
    logic [W-1:0] pv_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tally_onehot #(.N(N), .MODE(OUT_REG)) u_tally_onehot (
        .clk(clk), .rst(rst), .bits_i(bits), .onehot_o(out_reg));

    tally_onehot #(.N(N), .MODE(OUT_COMB)) u_tally_onehot_comb (
        .clk(clk), .rst(rst), .bits_i(bits), .onehot_o(out_comb));

    tally_stage #(.W(W)) u_stage_probe (
        .vec_i(pv_in), .bit_i(pbit), .vec_o(pv_out));

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) if (v[i]) c++;
        return c;
    endfunction

    function automatic logic [N:0] expect_vec(input logic [N-1:0] v);
        return (N+1)'(1) << ones(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        bits = 4'b1011;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(out_reg == 5'b00001, "R7 reset state", out_reg, 5'b00001);
        rst = 1'b0;
    endtask

    task automatic t_exhaustive;
        for (int v = 0; v < (1 << N); v++) begin
            logic [N:0] e;
            int hi;
            @(negedge clk);
            bits = N'(v);
            e = expect_vec(N'(v));
            #1;
            chk(out_comb == e, "R8 comb follows input / R2 count", out_comb, e);
            @(posedge clk);
            @(negedge clk);
            hi = 0;
            for (int i = 0; i <= N; i++) if (out_reg[i]) hi++;
            chk(hi == 1, "R1 exactly one bit high", out_reg, e);
            chk(out_reg == e, "R2 index equals popcount", out_reg, e);
        end
    endtask

    task automatic t_corners;
        @(negedge clk);
        bits = '0;
        @(posedge clk); @(negedge clk);
        chk(out_reg == 5'b00001, "R5 all zero gives bit 0", out_reg, 5'b00001);
        bits = '1;
        @(posedge clk); @(negedge clk);
        chk(out_reg == 5'b10000, "R5 all one gives bit N", out_reg, 5'b10000);
    endtask

    task automatic t_order;
        logic [N-1:0] pats [8] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                  4'b0011, 4'b0101, 4'b1010, 4'b1100};
        for (int i = 0; i < 8; i++) begin
            logic [N:0] e;
            e = (i < 4) ? 5'b00010 : 5'b00100;
            @(negedge clk);
            bits = pats[i];
            #1;
            chk(out_comb == e, "R9 position of set bits irrelevant", out_comb, e);
        end
    endtask

    task automatic t_stage;
        pv_in = 5'b00100; pbit = 1'b0; #1;
        chk(pv_out == 5'b00100, "R3 pass straight", pv_out, 5'b00100);
        pbit = 1'b1; #1;
        chk(pv_out == 5'b01000, "R4 shift up one", pv_out, 5'b01000);
        pv_in = 5'b00001; #1;
        chk(pv_out == 5'b00010 && !pv_out[0], "R4 bottom driven low", pv_out, 5'b00010);
        pv_in = 5'b10000; pbit = 1'b0; #1;
        chk(pv_out == 5'b10000, "R3 top line passes", pv_out, 5'b10000);
    endtask

    task automatic t_hold;
        @(negedge clk);
        bits = 4'b0001;
        @(posedge clk); @(negedge clk);
        bits = 4'b0111;
        #1;
        chk(out_reg == 5'b00010, "R6 holds until next edge", out_reg, 5'b00010);
        @(posedge clk); @(negedge clk);
        chk(out_reg == 5'b01000, "R6 updates after edge", out_reg, 5'b01000);
    endtask

    task automatic t_reset_collide;
        @(negedge clk);
        bits = '1;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(out_reg == 5'b00001, "R7 reset beats inputs", out_reg, 5'b00001);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(out_reg == 5'b10000, "R6 resumes after reset", out_reg, 5'b10000);
    endtask

    initial begin
        t_reset();
        t_stage();
        t_exhaustive();
        t_corners();
        t_order();
        t_hold();
        t_reset_collide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule